// File: doc/BRIEF.md
# NAND Page Program and Erase Engine

This block models the storage side of a small NAND flash device. It holds an array of pages grouped into erase blocks. Each page carries a spare area of one thirty-second of its data size, stored directly after the data columns. A sequencer drives single-cycle commands into the engine, one per cycle. Program setup opens a page buffer that collects bytes from a write port. Commit merges that buffer into the stored page. Erase restores a whole block. Read opens a page for byte-serial read-out through a port whose pointer advances on each acknowledge.

The cells follow flash rules. A commit can only clear bits, because each buffered byte is ANDed into the stored byte. Only an erase brings bits back to one. An active-low write-protect input blocks commit and erase. A spare-offset command moves the next commit or read to the first spare column. A spare-skip input shortens a read so that it stops at the end of the data columns. After each commit or erase, the engine holds a busy flag for a fixed number of cycles. While busy is high, every command is ignored.

Top module: `nand_page_engine`

## Requirements
- R1: After reset every stored byte is 0xFF, `busy` is low and `rd_avail` is low.
- R2: A page row holds PAGE_BYTES data bytes at columns 0..PAGE_BYTES-1, followed by PAGE_BYTES/32 spare bytes at the next columns. The default is 64 data bytes plus 2 spare bytes, so columns 0..65.
- R3: After program setup (code 0, page and column latched), each `wr_valid` byte is stored in the buffer, up to the full row length. Later bytes are discarded.
- R4: Commit (code 1) ANDs buffer byte j into column start+j of the latched page, where start is the latched column plus the pending offset. Bytes that land past the last spare column are dropped.
- R5: The spare-offset command (code 4) sets the pending offset to PAGE_BYTES. The next accepted commit or read clears it back to 0.
- R6: Erase (code 2) aligns the page address down to a multiple of PAGES_PER_BLOCK. It then sets every data and spare byte of that block to 0xFF and leaves other blocks unchanged.
- R7: While `wp_n` is low, commit and erase leave the array unchanged.
- R8: Read (code 3) at start column s makes (row length − s) bytes available, or (PAGE_BYTES − s) when `spare_skip` is high, and none when s is at or past that limit. `rd_data` shows the byte at the pointer while `rd_avail` is high and 0 otherwise. Each `rd_ack` advances the pointer by one.
- R9: A page address at or above NUM_PAGES (12 by default) makes a read supply no bytes. It also makes commit and erase leave the array unchanged.
- R10: An accepted commit or erase holds `busy` high for exactly BUSY_CYCLES cycles, starting in the next cycle, whether or not the array changed. Commands presented while `busy` is high are ignored.
- R11: Command codes 5 to 7 are ignored. An accepted command takes priority over a same-cycle write byte or read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 setup, 1 commit, 2 erase, 3 read, 4 spare offset) |
| cmd_page | input | clog2(NUM_PAGES) (4) | Page address |
| cmd_col | input | clog2(row length) (7) | Column address |
| wp_n | input | 1 | Write protect, active low |
| spare_skip | input | 1 | Read stops at end of data columns |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_ack | input | 1 | Consume current read byte |
| rd_avail | output | 1 | Read byte available |
| rd_data | output | 8 | Byte at read pointer |
| busy | output | 1 | Commit or erase in progress |

## Verification
A first program into an erased page shows whether the buffer is stored as written and whether the 67th to 70th bytes are dropped. A second program, with an alternating nibble pattern at a nonzero column, then separates a true AND from an overwrite and checks the column alignment. Writes aimed at the spare columns, made through both the column address and the spare offset, exercise clipping at the row end and the clearing of the offset. Erase with protection off and on, reads from out-of-range pages, and commands issued during busy show that the array and the read state stay untouched where they must.

// File: rtl/nand_eng_pkg.sv
// Shared command encoding for the NAND page engine.
package nand_eng_pkg;
    typedef enum logic [2:0] {
        OP_SETUP  = 3'd0,
        OP_COMMIT = 3'd1,
        OP_ERASE  = 3'd2,
        OP_READ   = 3'd3,
        OP_SPARE  = 3'd4
    } eng_op_e;
endpackage

// File: rtl/nand_busy_timer.sv
// Busy timer: holds busy for CYCLES cycles after a start pulse.
// Assumes start is only pulsed while busy is low.
module nand_busy_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              left <= '0;
        else if (start)          left <= CW'(CYCLES);
        else if (left != '0)     left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/nand_prog_buffer.sv
// Program buffer: collects bytes up to TOTAL after a clear.
// Assumes clear and wr_en are never high together.
module nand_prog_buffer #(
    parameter int TOTAL = 66,
    parameter int CNTW  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [TOTAL*8-1:0] data_flat,
    output logic [CNTW-1:0]    count
);
    // Byte count: reset by clear, capped at TOTAL.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                         count <= '0;
        else if (wr_en && int'(count) < TOTAL)       count <= count + 1'b1;
    end

    // Byte storage: write at current count while room remains.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_flat <= '1;
        else if (wr_en && int'(count) < TOTAL)
            data_flat[int'(count)*8 +: 8] <= wr_data;
    end
endmodule

// File: rtl/nand_cell_array.sv
// Cell array: pages of data plus spare columns. Commit ANDs buffer
// bytes into one page, erase fills one block with 0xFF.
// Assumes enables are already gated for range and protection.
module nand_cell_array #(
    parameter int TOTAL     = 66,
    parameter int PPB       = 4,
    parameter int NUM_PAGES = 12,
    parameter int PAW       = 4,
    parameter int CAW       = 7,
    parameter int CNTW      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic [PAW-1:0]     prog_page,
    input  logic [CAW:0]       prog_start,
    input  logic [CNTW-1:0]    prog_count,
    input  logic [TOTAL*8-1:0] prog_data,
    input  logic               erase_en,
    input  logic [PAW-1:0]     erase_page,
    input  logic [PAW-1:0]     rd_page,
    input  logic [CAW:0]       rd_col,
    output logic [7:0]         rd_byte
);
    logic [7:0] cells [NUM_PAGES][TOTAL];

    // Cell update: reset fill, block erase, or AND merge of buffer.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PAGES; p++) begin
            for (int i = 0; i < TOTAL; i++) begin
                if (!rst_n) begin
                    cells[p][i] <= 8'hFF;
                end else if (erase_en && (p / PPB) == (int'(erase_page) / PPB)) begin
                    cells[p][i] <= 8'hFF;
                end else if (prog_en && p == int'(prog_page) &&
                             i >= int'(prog_start) &&
                             (i - int'(prog_start)) < int'(prog_count)) begin
                    cells[p][i] <= cells[p][i] &
                                   prog_data[(i - int'(prog_start))*8 +: 8];
                end
            end
        end
    end

    // Read tap: byte at page and column, 0xFF when outside the array.
    always_comb begin
        rd_byte = 8'hFF;
        if (int'(rd_page) < NUM_PAGES && int'(rd_col) < TOTAL)
            rd_byte = cells[rd_page][rd_col[CAW-1:0]];
    end
endmodule

// File: rtl/nand_page_engine.sv
// NAND page engine top: decodes commands, tracks program setup,
// spare offset and read pointer, and drives the array and busy timer.
// Assumes one command per cycle from a single sequencer.
module nand_page_engine #(
    parameter int PAGE_BYTES      = 64,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int NUM_BLOCKS      = 3,
    parameter int BUSY_CYCLES     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [$clog2(NUM_BLOCKS*PAGES_PER_BLOCK)-1:0] cmd_page,
    input  logic [$clog2(PAGE_BYTES+PAGE_BYTES/32)-1:0]   cmd_col,
    input  logic wp_n,
    input  logic spare_skip,
    input  logic wr_valid,
    input  logic [7:0] wr_data,
    input  logic rd_ack,
    output logic rd_avail,
    output logic [7:0] rd_data,
    output logic busy
);
    import nand_eng_pkg::*;

    localparam int SPARE     = PAGE_BYTES / 32;
    localparam int TOTAL     = PAGE_BYTES + SPARE;
    localparam int NUM_PAGES = NUM_BLOCKS * PAGES_PER_BLOCK;
    localparam int PAW       = $clog2(NUM_PAGES);
    localparam int CAW       = $clog2(TOTAL);
    localparam int CNTW      = $clog2(TOTAL + 1);

    eng_op_e op;
    logic accept, page_ok, is_commit, is_erase, is_read, is_setup, is_spare;
    logic setup_mode;
    logic [CAW:0]   offset, rd_start, rd_limit, rd_ptr, rd_left, prog_start;
    logic [PAW-1:0] prog_page, rd_page;
    logic [CAW-1:0] prog_col;
    logic [TOTAL*8-1:0] buf_flat;
    logic [CNTW-1:0]    buf_count;
    logic [7:0]         cell_byte;

    // Command decode and derived addresses.
    always_comb begin
        op         = eng_op_e'(cmd_op);
        accept     = cmd_valid && !busy;
        page_ok    = int'(cmd_page) < NUM_PAGES;
        is_setup   = accept && op == OP_SETUP;
        is_commit  = accept && op == OP_COMMIT;
        is_erase   = accept && op == OP_ERASE;
        is_read    = accept && op == OP_READ;
        is_spare   = accept && op == OP_SPARE;
        rd_start   = {1'b0, cmd_col} + offset;
        rd_limit   = spare_skip ? (CAW+1)'(PAGE_BYTES) : (CAW+1)'(TOTAL);
        prog_start = {1'b0, prog_col} + offset;
    end

    // Program setup state: mode flag and latched page/column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_mode <= 1'b0;
            prog_page  <= '0;
            prog_col   <= '0;
        end else if (is_setup) begin
            setup_mode <= 1'b1;
            prog_page  <= cmd_page;
            prog_col   <= cmd_col;
        end else if (is_commit || is_erase || is_read) begin
            setup_mode <= 1'b0;
        end
    end

    // Pending column offset: set by spare command, cleared by commit/read.
    always_ff @(posedge clk) begin
        if (!rst_n)                    offset <= '0;
        else if (is_spare)             offset <= (CAW+1)'(PAGE_BYTES);
        else if (is_commit || is_read) offset <= '0;
    end

    // Read pointer and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_page <= '0;
            rd_ptr  <= '0;
            rd_left <= '0;
        end else if (is_read) begin
            rd_page <= cmd_page;
            rd_ptr  <= rd_start;
            rd_left <= (page_ok && rd_start < rd_limit) ? rd_limit - rd_start : '0;
        end else if (is_setup || is_commit || is_erase) begin
            rd_left <= '0;
        end else if (!accept && rd_ack && rd_left != '0) begin
            rd_ptr  <= rd_ptr + 1'b1;
            rd_left <= rd_left - 1'b1;
        end
    end

    nand_prog_buffer #(.TOTAL(TOTAL), .CNTW(CNTW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (is_setup),
        .wr_en     (!accept && wr_valid && setup_mode),
        .wr_data   (wr_data),
        .data_flat (buf_flat),
        .count     (buf_count)
    );

    nand_cell_array #(
        .TOTAL(TOTAL), .PPB(PAGES_PER_BLOCK), .NUM_PAGES(NUM_PAGES),
        .PAW(PAW), .CAW(CAW), .CNTW(CNTW)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (is_commit && wp_n && int'(prog_page) < NUM_PAGES),
        .prog_page  (prog_page),
        .prog_start (prog_start),
        .prog_count (buf_count),
        .prog_data  (buf_flat),
        .erase_en   (is_erase && wp_n && page_ok),
        .erase_page (cmd_page),
        .rd_page    (rd_page),
        .rd_col     (rd_ptr),
        .rd_byte    (cell_byte)
    );

    nand_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (is_commit || is_erase),
        .busy  (busy)
    );

    assign rd_avail = (rd_left != '0);
    assign rd_data  = rd_avail ? cell_byte : 8'h00;
endmodule

// File: rtl/nand_engine_checks.sv
// Port-level checks for the NAND page engine, bound to the top.
module nand_engine_checks #(
    parameter int BUSY_CYCLES = 6,
    parameter int NUM_PAGES   = 12,
    parameter int PAW         = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [2:0]     cmd_op,
    input logic [PAW-1:0] cmd_page,
    input logic           rd_ack,
    input logic           rd_avail,
    input logic [7:0]     rd_data,
    input logic           busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 2);
    logic [BW-1:0] busy_run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2))); // R10
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int'(busy_run) == BUSY_CYCLES); // R10
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> int'(busy_run) < BUSY_CYCLES); // R10
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && cmd_op == 3'd3 && !rd_avail) |=> !rd_avail); // R10
    AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd3 && int'(cmd_page) >= NUM_PAGES) |=> !rd_avail); // R9
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && !cmd_valid && !rd_ack) |=> (rd_avail && $stable(rd_data))); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_avail |-> rd_data == 8'h00); // R8
endmodule

bind nand_page_engine nand_engine_checks #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .NUM_PAGES   (NUM_BLOCKS * PAGES_PER_BLOCK),
    .PAW         ($clog2(NUM_BLOCKS * PAGES_PER_BLOCK))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_page  (cmd_page),
    .rd_ack    (rd_ack),
    .rd_avail  (rd_avail),
    .rd_data   (rd_data),
    .busy      (busy)
);

// File: tb/sim_nand_page_engine.sv
module sim_nand_page_engine;
    localparam int PB = 64, SP = 2, TOT = 66, PPB = 4, NP = 12, BC = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, wp_n = 1, spare_skip = 0, wr_valid = 0, rd_ack = 0;
    logic [2:0] cmd_op = 0;
    logic [3:0] cmd_page = 0;
    logic [6:0] cmd_col = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic rd_avail, busy;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit finished = 0;

    // reference model state
    logic [7:0] mm [NP][TOT];
    logic [7:0] mbuf [TOT];
    int mcnt = 0, mppage = 0, mpcol = 0, mofs = 0, mbusy = 0;
    int mrpage = 0, mrptr = 0, mrem = 0;
    bit mprog = 0;

    always #4 clk = ~clk;

    nand_page_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cmd_col(cmd_col), .wp_n(wp_n),
        .spare_skip(spare_skip), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_ack(rd_ack), .rd_avail(rd_avail), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model update for the inputs present at the last clock edge.
    task automatic model_apply();
        bit acc;
        int st, lim;
        acc = cmd_valid && mbusy == 0;
        if (mbusy > 0) mbusy--;
        if (acc) begin
            case (cmd_op)
                3'd0: begin mprog = 1; mcnt = 0; mppage = cmd_page; mpcol = cmd_col; mrem = 0; end
                3'd1: begin
                    if (wp_n && mppage < NP)
                        for (int j = 0; j < mcnt; j++)
                            if (mpcol + mofs + j < TOT)
                                mm[mppage][mpcol+mofs+j] = mm[mppage][mpcol+mofs+j] & mbuf[j];
                    mofs = 0; mprog = 0; mrem = 0; mbusy = BC;
                end
                3'd2: begin
                    if (wp_n && cmd_page < NP)
                        for (int p = 0; p < NP; p++)
                            if (p / PPB == int'(cmd_page) / PPB)
                                for (int i = 0; i < TOT; i++) mm[p][i] = 8'hFF;
                    mprog = 0; mrem = 0; mbusy = BC;
                end
                3'd3: begin
                    st = int'(cmd_col) + mofs; mofs = 0; mprog = 0;
                    lim = spare_skip ? PB : TOT;
                    mrpage = cmd_page; mrptr = st;
                    mrem = (cmd_page < NP && st < lim) ? lim - st : 0;
                end
                3'd4: mofs = PB;
                default: ;
            endcase
        end else begin
            if (wr_valid && mprog && mcnt < TOT) begin mbuf[mcnt] = wr_data; mcnt++; end
            if (rd_ack && mrem > 0) begin mrptr++; mrem--; end
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        if (rst_n) model_apply();
        cmd_valid = 0; wr_valid = 0; rd_ack = 0;
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R10", "busy", busy, mbusy > 0);
            check("R8", "rd_avail", rd_avail, mrem > 0);
            check(cur_req, "rd_data", rd_data, mrem > 0 ? int'(mm[mrpage][mrptr]) : 0);
        end
    end

    task automatic issue(input int op, input int page, input int col);
        cmd_valid = 1; cmd_op = 3'(op); cmd_page = 4'(page); cmd_col = 7'(col);
        tick();
    endtask

    task automatic write_bytes(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            wr_valid = 1; wr_data = 8'((k * seed + 8'h3C) ^ (k << 2));
            tick();
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 50 && busy; k++) tick();
    endtask

    task automatic read_expect(input string req, input int page, input int col, input int expn);
        int n;
        issue(3, page, col);
        n = 0;
        while (rd_avail && n < 200) begin rd_ack = 1; tick(); n++; end
        check(req, "bytes read", n, expn);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1; fails++; checks++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int bc;
        for (int p = 0; p < NP; p++) for (int i = 0; i < TOT; i++) mm[p][i] = 8'hFF;
        for (int i = 0; i < TOT; i++) mbuf[i] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        check("R1", "busy after reset", busy, 0);
        check("R1", "rd_avail after reset", rd_avail, 0);
        read_expect("R1", 0, 0, TOT);
        read_expect("R1", 11, 0, TOT);

        cur_req = "R3"; // 70 bytes, only 66 kept
        issue(0, 2, 0); write_bytes(70, 7); issue(1, 0, 0); wait_idle();
        read_expect("R3", 2, 0, TOT);

        cur_req = "R4"; // AND with nibble pattern at column 10
        issue(0, 2, 10);
        for (int k = 0; k < 8; k++) begin wr_valid = 1; wr_data = k[0] ? 8'h0F : 8'hF0; tick(); end
        issue(1, 0, 0); wait_idle();
        read_expect("R4", 2, 0, TOT);

        cur_req = "R2"; // spare columns reached via column address, clip at row end
        issue(0, 5, 64); write_bytes(3, 11); issue(1, 0, 0); wait_idle();
        read_expect("R2", 5, 63, 3);

        cur_req = "R5"; // spare offset for commit, then cleared
        issue(4, 0, 0); issue(0, 6, 0); write_bytes(2, 13); issue(1, 0, 0); wait_idle();
        read_expect("R5", 6, 0, TOT);
        issue(4, 0, 0);
        read_expect("R5", 6, 1, 1);
        read_expect("R5", 6, 0, TOT);

        cur_req = "R8";
        spare_skip = 1;
        read_expect("R8", 2, 5, PB - 5);
        read_expect("R8", 2, 65, 0);
        spare_skip = 0;
        read_expect("R8", 2, 60, TOT - 60);
        rd_ack = 1; tick(); rd_ack = 1; tick();

        cur_req = "R11"; // unknown code mid-read is ignored
        issue(3, 2, 0); rd_ack = 1; tick();
        issue(6, 0, 0);
        check("R11", "read kept after code 6", rd_avail, 1);
        cmd_valid = 1; cmd_op = 3'd5; rd_ack = 1; tick();
        check("R11", "ack ignored under command", rd_avail, mrem > 0);
        read_expect("R11", 2, 0, TOT);

        cur_req = "R7"; // protected erase and commit
        wp_n = 0;
        issue(2, 2, 0); wait_idle();
        issue(0, 2, 0); write_bytes(10, 0); issue(1, 0, 0); wait_idle();
        wp_n = 1;
        read_expect("R7", 2, 0, TOT);

        cur_req = "R6"; // erase block 0 via page 3
        issue(2, 3, 0); wait_idle();
        read_expect("R6", 2, 0, TOT);
        read_expect("R6", 5, 60, TOT - 60);
        read_expect("R6", 6, 60, TOT - 60);

        cur_req = "R9";
        read_expect("R9", 13, 0, 0);
        issue(0, 14, 0); write_bytes(4, 0); issue(1, 0, 0); wait_idle();
        issue(2, 12, 0); wait_idle();
        read_expect("R9", 11, 0, TOT);
        read_expect("R9", 5, 60, TOT - 60);

        cur_req = "R10"; // busy length and commands ignored while busy
        issue(2, 5, 0);
        bc = 0;
        issue(3, 5, 0);
        check("R10", "read ignored while busy", rd_avail, 0);
        bc = 1;
        while (busy && bc < 50) begin bc++; tick(); end
        check("R10", "busy cycles", bc, BC);
        read_expect("R10", 5, 60, TOT - 60);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule